// File: doc/BRIEF.md
# Write-Back Port Arbiter with Unit Back-Pressure

This block shares one register-file write port among five result-producing units: a divider, a multiplier, an adder, a memory unit and an integer ALU. The latency of each unit is treated as unknown, so the block does not schedule write-back at issue time. Instead it settles any conflict on every cycle. Each unit offers a finished result, which is a destination register number, a flag that selects the integer or floating-point file, and a data word, together with a valid bit. In each cycle the block grants exactly one of the units that are offering a result. The winning result appears on the write port one cycle later, for one cycle. Each losing unit receives a stall and must keep its result in place until it wins.

The block also tells the issue stage whether each unit can take a new operation. A unit is reported busy in two cases. The first is while it holds a result that has not been granted. The second is while it is inside its own occupancy window after a dispatch. An occupancy of one means the unit is fully pipelined. An occupancy of two means it is partially pipelined and accepts an operation every second cycle. Larger values model an unpipelined unit. Operands are assumed to be captured inside each unit at dispatch, so the block carries no source-operand state.

Each unit has its own tracker with three named states:
- **T_IDLE** means no result is held and the occupancy window is closed.
- **T_OCCUPY** means the occupancy window is still open.
- **T_HOLD** means the unit was stalled on the last cycle.

The tracker moves as follows. From any state, a stall moves it to **T_HOLD** ("blocked"). Without a stall, an open window after this cycle moves it to **T_OCCUPY** ("occupied"). Otherwise it moves to **T_IDLE** ("released"). Leaving **T_HOLD** on a grant is therefore the "granted" transition. Leaving **T_IDLE** on a dispatch with an occupancy above one is the "dispatched" transition.

Top module: `wb_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `wr_en` is 0 and every bit of `unit_busy` is 0 when no result is offered.
- R2: In every cycle `grant` has at most one bit set, and exactly one bit is set whenever any bit of `res_valid` is set. A grant goes only to a unit whose `res_valid` is set.
- R3: Priority is fixed by unit index, and a lower index wins. Index 0 is the divider, 1 the multiplier, 2 the adder, 3 the memory unit and 4 the ALU.
- R4: `res_stall[u]` is 1 exactly when unit u offers a result and is not granted in that cycle.
- R5: In the cycle after a grant, `wr_en` is 1 and `wr_fp`, `wr_dest` and `wr_data` equal the fields the granted unit offered. In the cycle after a cycle with no grant, `wr_en` is 0.
- R6: `unit_busy[u]` is 1 in every cycle in which unit u is stalled.
- R7: A dispatch into unit u makes `unit_busy[u]` 1 for the next OCC−1 cycles and 0 afterwards, if the unit has no stalled result. The default occupancies are 4 for the divider, 2 for the multiplier and 1 for the others.
- R8: Under sustained contention, every offered result is written exactly once, and the results of each unit are written in the order that unit produced them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dispatch | input | 5 | Issue puts an operation into unit u this cycle |
| res_valid | input | 5 | Unit u offers a finished result |
| res_fp | input | 5 | Target is the FP file (1) or the integer file (0), per unit |
| res_dest | input | 25 | Destination register per unit, 5 bits each, unit u at [5u+4:5u] |
| res_data | input | 160 | Result word per unit, 32 bits each, unit u at [32u+31:32u] |
| res_stall | output | 5 | Back-pressure: unit u must hold its result |
| unit_busy | output | 5 | Issue must not dispatch into unit u |
| grant | output | 5 | One-hot grant of this cycle |
| wr_en | output | 1 | Register-file write enable |
| wr_fp | output | 1 | Selects the FP file for the write |
| wr_dest | output | 5 | Register written |
| wr_data | output | 32 | Word written |

## Verification
The bench aims at the following corner cases:
- **All five units offering at once.** A wrong priority order would write a short-latency result ahead of the divider.
- **Single offers from each position.** A grant that leaks to a non-requesting unit, or a missing grant, would show as a wrong `wr_en`.
- **Sustained contention from latency-driven stub units.** These hold their results while stalled. A block that drops a stalled result or writes it twice breaks the per-unit sequence numbers carried in the data.
- **Occupancy after a dispatch, for each pipelining style.** An off-by-one in the window would show as the unit freeing a cycle early or late.

// File: rtl/wb_pkg.sv
package wb_pkg;
    localparam int NUM_UNITS = 5;
    localparam int U_DIV = 0;
    localparam int U_MUL = 1;
    localparam int U_ADD = 2;
    localparam int U_MEM = 3;
    localparam int U_ALU = 4;

    typedef enum logic [1:0] {
        T_IDLE,
        T_OCCUPY,
        T_HOLD
    } trk_state_e;
endpackage

// File: rtl/wb_prio_arb.sv
module wb_prio_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    // lowest set bit wins: index 0 has top priority
    always_comb begin
        gnt = req & (~req + N'(1));
    end

    p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    p_grant_when_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|gnt));
    p_grant_subset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
    p_top_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req[0] |-> gnt[0]);
endmodule

// File: rtl/wb_unit_track.sv
module wb_unit_track #(
    parameter int OCC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dispatch,
    input  logic res_valid,
    input  logic grant,
    output logic stall,
    output logic busy
);
    import wb_pkg::*;

    localparam int CW = $clog2(OCC + 1);

    trk_state_e      st_q, st_d;
    logic [CW-1:0]   occ_q, occ_d;

    always_comb begin
        stall = res_valid & ~grant;
        if (dispatch)
            occ_d = CW'(OCC - 1);
        else if (occ_q != '0)
            occ_d = occ_q - CW'(1);
        else
            occ_d = occ_q;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            T_IDLE: begin
                if (stall)             st_d = T_HOLD;
                else if (occ_d != '0)  st_d = T_OCCUPY;
            end
            T_OCCUPY: begin
                if (stall)             st_d = T_HOLD;
                else if (occ_d == '0)  st_d = T_IDLE;
            end
            T_HOLD: begin
                if (!stall)            st_d = (occ_d != '0) ? T_OCCUPY : T_IDLE;
            end
            default:                   st_d = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= T_IDLE;
            occ_q <= '0;
        end else begin
            st_q  <= st_d;
            occ_q <= occ_d;
        end
    end

    always_comb begin
        unique case (st_q)
            T_IDLE:   busy = stall;
            T_OCCUPY: busy = 1'b1;
            T_HOLD:   busy = stall | (occ_q != '0);
            default:  busy = 1'b0;
        endcase
    end

    p_busy_when_stalled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> busy);
    p_occupy_after_dispatch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dispatch && OCC > 1) |=> busy);
    p_no_dispatch_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dispatch);
endmodule

// File: rtl/wb_arbiter.sv
module wb_arbiter #(
    parameter int RW      = 5,
    parameter int DW      = 32,
    parameter int OCC_DIV = 4,
    parameter int OCC_MUL = 2,
    parameter int OCC_ADD = 1,
    parameter int OCC_MEM = 1,
    parameter int OCC_ALU = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [wb_pkg::NUM_UNITS-1:0]  dispatch,
    input  logic [wb_pkg::NUM_UNITS-1:0]  res_valid,
    input  logic [wb_pkg::NUM_UNITS-1:0]  res_fp,
    input  logic [wb_pkg::NUM_UNITS*RW-1:0] res_dest,
    input  logic [wb_pkg::NUM_UNITS*DW-1:0] res_data,
    output logic [wb_pkg::NUM_UNITS-1:0]  res_stall,
    output logic [wb_pkg::NUM_UNITS-1:0]  unit_busy,
    output logic [wb_pkg::NUM_UNITS-1:0]  grant,
    output logic                          wr_en,
    output logic                          wr_fp,
    output logic [RW-1:0]                 wr_dest,
    output logic [DW-1:0]                 wr_data
);
    import wb_pkg::*;

    localparam int NU = NUM_UNITS;
    localparam int OCC_TAB [NU] = '{OCC_DIV, OCC_MUL, OCC_ADD, OCC_MEM, OCC_ALU};

    logic          sel_fp;
    logic [RW-1:0] sel_dest;
    logic [DW-1:0] sel_data;

    wb_prio_arb #(.N(NU)) i_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (res_valid),
        .gnt   (grant)
    );

    for (genvar g = 0; g < NU; g++) begin : g_unit
        wb_unit_track #(.OCC(OCC_TAB[g])) i_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .dispatch  (dispatch[g]),
            .res_valid (res_valid[g]),
            .grant     (grant[g]),
            .stall     (res_stall[g]),
            .busy      (unit_busy[g])
        );
    end

    // one-hot OR mux of the winning result
    always_comb begin
        sel_fp   = 1'b0;
        sel_dest = '0;
        sel_data = '0;
        for (int u = 0; u < NU; u++) begin
            if (grant[u]) begin
                sel_fp   = sel_fp   | res_fp[u];
                sel_dest = sel_dest | res_dest[u*RW +: RW];
                sel_data = sel_data | res_data[u*DW +: DW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_fp   <= 1'b0;
            wr_dest <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= |grant;
            if (|grant) begin
                wr_fp   <= sel_fp;
                wr_dest <= sel_dest;
                wr_data <= sel_data;
            end
        end
    end

    p_write_follows_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |=> wr_en);
    p_no_write_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(|grant) |=> !wr_en);
    p_stall_loser_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_stall & grant) == '0);
endmodule

// File: tb/test_wb_arbiter.sv
module test_wb_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int NU = 5;
    localparam int RW = 5;
    localparam int DW = 32;
    localparam int N_RES = 20;
    // {offered requests, expected grant}, bit 0 = divider
    localparam logic [9:0] VEC [9] = '{
        {5'b00001, 5'b00001}, {5'b00011, 5'b00001}, {5'b00110, 5'b00010},
        {5'b11100, 5'b00100}, {5'b11000, 5'b01000}, {5'b10000, 5'b10000},
        {5'b11111, 5'b00001}, {5'b00000, 5'b00000}, {5'b01010, 5'b00010}
    };
    localparam int LAT [NU] = '{4, 3, 2, 1, 0};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NU-1:0]     dispatch = '0;
    logic [NU-1:0]     res_valid = '0;
    logic [NU-1:0]     res_fp = '0;
    logic [NU*RW-1:0]  res_dest = '0;
    logic [NU*DW-1:0]  res_data = '0;
    logic [NU-1:0]     res_stall, unit_busy, grant;
    logic              wr_en, wr_fp;
    logic [RW-1:0]     wr_dest;
    logic [DW-1:0]     wr_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wb_arbiter i_wb_arbiter (
        .clk(clk), .rst_n(rst_n), .dispatch(dispatch), .res_valid(res_valid),
        .res_fp(res_fp), .res_dest(res_dest), .res_data(res_data),
        .res_stall(res_stall), .unit_busy(unit_busy), .grant(grant),
        .wr_en(wr_en), .wr_fp(wr_fp), .wr_dest(wr_dest), .wr_data(wr_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mk_data(input int u, input int tag);
        return {4'(u), 12'h0, 16'(tag)};
    endfunction
    function automatic logic [RW-1:0] mk_dest(input int u, input int tag);
        return RW'(u * 6 + tag);
    endfunction

    task automatic offer(input logic [NU-1:0] req, input int tag);
        res_valid = req;
        for (int u = 0; u < NU; u++) begin
            res_fp[u] = (u < 3);
            res_dest[u*RW +: RW] = mk_dest(u, tag);
            res_data[u*DW +: DW] = mk_data(u, tag);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    int seq [NU];
    int cnt [NU];
    bit vld [NU];

    initial begin
        // R1: reset state
        #(CLK_PERIOD * 2 + 1);
        chk(wr_en == 1'b0, "R1 wr_en in reset", 64'(wr_en), 0);
        chk(unit_busy == '0, "R1 busy in reset", 64'(unit_busy), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(wr_en == 1'b0, "R1 wr_en after reset", 64'(wr_en), 0);
        chk(unit_busy == '0 && grant == '0, "R1 busy/grant after reset", 64'({unit_busy, grant}), 0);

        // vector table: R2 R3 R4 R5 R6
        for (int k = 0; k < 9; k++) begin
            logic [NU-1:0] rq, eg;
            int w;
            rq = VEC[k][9:5];
            eg = VEC[k][4:0];
            @(negedge clk);
            offer(rq, k + 1);
            #1;
            chk(grant == eg, "R2/R3 grant", 64'(grant), 64'(eg));
            chk(res_stall == (rq & ~eg), "R4 stall", 64'(res_stall), 64'(rq & ~eg));
            chk((unit_busy & res_stall) == res_stall, "R6 busy covers stall", 64'(unit_busy), 64'(res_stall));
            w = -1;
            for (int u = NU - 1; u >= 0; u--) if (eg[u]) w = u;
            @(posedge clk); #1;
            if (w < 0) begin
                chk(wr_en == 1'b0, "R5 no write", 64'(wr_en), 0);
            end else begin
                chk(wr_en && wr_data == mk_data(w, k + 1) && wr_dest == mk_dest(w, k + 1)
                    && wr_fp == (w < 3), "R5 write fields",
                    64'({wr_en, wr_fp, wr_dest, wr_data}),
                    64'({1'b1, 1'(w < 3), mk_dest(w, k + 1), mk_data(w, k + 1)}));
            end
        end
        @(negedge clk); offer('0, 0);
        @(negedge clk);

        // R7: occupancy windows after dispatch (divider 4, multiplier 2, ALU 1)
        dispatch = 5'b10011;
        @(negedge clk); dispatch = '0;
        chk(unit_busy == 5'b00011, "R7 cycle1 busy", 64'(unit_busy), 64'(5'b00011));
        @(negedge clk);
        chk(unit_busy == 5'b00001, "R7 cycle2 busy", 64'(unit_busy), 64'(5'b00001));
        @(negedge clk);
        chk(unit_busy == 5'b00001, "R7 cycle3 busy", 64'(unit_busy), 64'(5'b00001));
        @(negedge clk);
        chk(unit_busy == 5'b00000, "R7 window closed", 64'(unit_busy), 0);

        // R6 with R7: stall of multiplier inside divider window
        dispatch = 5'b00001;
        @(negedge clk); dispatch = '0;
        offer(5'b00011, 50);
        #1;
        chk(unit_busy == 5'b00011, "R6 stalled mul busy", 64'(unit_busy), 64'(5'b00011));
        @(negedge clk); offer(5'b00010, 50);
        #1;
        chk(unit_busy == 5'b00001, "R6 released mul", 64'(unit_busy), 64'(5'b00001));
        @(negedge clk); offer('0, 0);
        repeat (3) @(negedge clk);

        // R8: stub units with latencies, hold while stalled, per-unit order
        for (int u = 0; u < NU; u++) begin seq[u] = 0; cnt[u] = LAT[u]; vld[u] = 1'b0; end
        begin
            int pg;
            int guard;
            bit busy_any;
            pg = -1;
            guard = 0;
            busy_any = 1'b1;
            while (busy_any && guard < 5000) begin
                guard++;
                @(posedge clk); #1;
                if (pg >= 0) begin
                    chk(wr_en && wr_data == mk_data(pg, seq[pg]), "R8 retire order",
                        64'(wr_data), 64'(mk_data(pg, seq[pg])));
                    seq[pg]++;
                    vld[pg] = 1'b0;
                    cnt[pg] = LAT[pg] + (seq[pg] % 2);
                end
                for (int u = 0; u < NU; u++) begin
                    if (u != pg && !vld[u] && seq[u] < N_RES) begin
                        if (cnt[u] == 0) vld[u] = 1'b1;
                        else cnt[u]--;
                    end
                    res_valid[u] = vld[u];
                    res_fp[u] = (u < 3);
                    res_dest[u*RW +: RW] = mk_dest(u, seq[u]);
                    res_data[u*DW +: DW] = mk_data(u, seq[u]);
                end
                #1;
                pg = -1;
                for (int u = NU - 1; u >= 0; u--) if (vld[u]) pg = u;
                if (pg >= 0)
                    chk(grant == (5'b1 << pg), "R3 stream priority", 64'(grant), 64'(5'b1 << pg));
                busy_any = 1'b0;
                for (int u = 0; u < NU; u++) if (seq[u] < N_RES) busy_any = 1'b1;
            end
            for (int u = 0; u < NU; u++)
                chk(seq[u] == N_RES, "R8 all retired once", 64'(seq[u]), 64'(N_RES));
        end
        offer('0, 0);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule